// File: doc/BRIEF.md
# Ping-Pong Row Buffer for a Separable 2D Transform

This block sits between the row stage and the column stage of a separable two-dimensional transform. It holds two banks, each one row of eight intermediate words. The first stage streams the words of a row into the bank currently assigned to writing. Meanwhile the second stage reads, by address, the bank that holds the previous complete row. The read bank is always the opposite of the write bank, so a reader can never see a row that is only partly written.

Words are written in arrival order. The write position is an internal counter, so the producer only raises a valid strobe. The producer delivers rows in the same pattern for every block along a picture line, and in a four-phase schedule it strobes a write in the phase that updates internal memory. When the eighth word of a row is accepted, the banks swap roles. A one-cycle pulse marks the swap, and the read-available flag is set.

The reader marks the end of its use of a row with a release strobe. If the producer offers the last word of a row while the reader still holds the other bank, the swap would take that bank away from the reader. The block therefore refuses that word, raises an error pulse, and keeps both banks where they are. The producer can then offer the word again. A release in the same cycle as the last word counts, and the word is accepted.

Top module: `pp_row_buffer`

## Requirements
- R1: After synchronous reset, wr_bank is 0, rd_avail is 0, swap is 0, wr_err is 0 and rd_data is 0.
- R2: The accepted words of a row occupy positions 0 to 7 in arrival order. After the swap, a read at rd_addr k returns the k-th accepted word of that row.
- R3: The cycle after the eighth accepted word of a row, swap is 1 for exactly one cycle and wr_bank has toggled. wr_bank does not change at any other time.
- R4: rd_avail becomes 1 with the swap and stays 1 until a cycle with rd_release high. The cycle after that release it reads 0, unless a swap happens in the same cycle.
- R5: A last word (position 7) offered while rd_avail is 1 and rd_release is 0 is refused. The cycle after, wr_err is 1 for one cycle, swap stays 0, wr_bank is unchanged, and the word is not stored. A later successful offer stores its own value at position 7.
- R6: A last word offered in the same cycle as rd_release is accepted. The swap happens, rd_avail stays 1 and wr_err stays 0.
- R7: Reads always address the bank opposite to wr_bank. Writes to the write bank in the same cycles leave the row being read unchanged.
- R8: rd_data is registered with one cycle of latency after a cycle with rd_en high, and it holds its value while rd_en is low.
- R9: Words at positions 0 to 6 are accepted while rd_avail is 1, with no error.
- R10: Cycles with wr_valid low do not advance the write position and do not cause a swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Offer one word to the write bank |
| wr_data | input | 16 | Word offered |
| rd_en | input | 1 | Read request for the read bank |
| rd_addr | input | 3 | Position within the read row |
| rd_release | input | 1 | Reader is finished with the read row |
| rd_data | output | 16 | Registered read result |
| rd_avail | output | 1 | A complete row is held for the reader |
| wr_bank | output | 1 | Bank being written; the read bank is its inverse |
| swap | output | 1 | One-cycle pulse after a row completes |
| wr_err | output | 1 | One-cycle pulse after a refused last word |

## Verification
Two pairs of functions can fall in the same cycle. The first is the reader's release and the producer's last word. The bench drives both strobes in one cycle and expects a swap with rd_avail still high and no error, then reads the new row back. It also offers a last word with no release and expects the refusal pulse, an unchanged bank, and the dropped value to be absent from the row after a retry. The second pair is a read and a write in the same cycle. The bench writes seven words of the next row while reading the held row in reverse address order, and the scoreboard checks every returned word against the row written earlier.

// File: rtl/pp_row_pkg.sv
package pp_row_pkg;
  localparam int DEF_WORD_W  = 16;
  localparam int DEF_ROW_LEN = 8;
  localparam int NUM_BANKS   = 2;
endpackage

// File: rtl/pp_row_ctl.sv
module pp_row_ctl #(
  parameter int ROW_LEN = pp_row_pkg::DEF_ROW_LEN
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_valid,
  input  logic                       rd_release,
  output logic                       wr_accept,
  output logic [$clog2(ROW_LEN)-1:0] wr_idx,
  output logic                       wr_bank,
  output logic                       swap,
  output logic                       wr_err,
  output logic                       rd_avail
);
  localparam int IDX_W = $clog2(ROW_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROW_LEN - 1);

  logic at_last;
  logic held;
  logic blocked;
  logic row_done;

  assign at_last   = (wr_idx == LAST_IDX);
  // a release in this cycle frees the reader's bank in time for the swap
  assign held      = rd_avail & ~rd_release;
  assign blocked   = wr_valid & at_last & held;            // R5
  assign wr_accept = wr_valid & ~blocked;
  assign row_done  = wr_accept & at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx   <= '0;
      wr_bank  <= 1'b0;
      swap     <= 1'b0;
      wr_err   <= 1'b0;
      rd_avail <= 1'b0;
    end else begin
      swap   <= row_done;                                  // R3
      wr_err <= blocked;
      if (wr_accept) begin
        if (at_last) begin
          wr_idx  <= '0;
          wr_bank <= ~wr_bank;
        end else begin
          wr_idx <= wr_idx + 1'b1;                         // R2, R10
        end
      end
      if (row_done)
        rd_avail <= 1'b1;                                  // R4, R6
      else if (rd_release)
        rd_avail <= 1'b0;
    end
  end
endmodule

// File: rtl/pp_row_mem.sv
module pp_row_mem #(
  parameter int WORD_W = pp_row_pkg::DEF_WORD_W,
  parameter int DEPTH  = pp_row_pkg::NUM_BANKS * pp_row_pkg::DEF_ROW_LEN
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WORD_W-1:0]        wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WORD_W-1:0]        rdata
);
  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (re)
      rdata <= store[raddr];                               // R8
  end
endmodule

// File: rtl/pp_row_buffer.sv
module pp_row_buffer #(
  parameter int WORD_W  = pp_row_pkg::DEF_WORD_W,
  parameter int ROW_LEN = pp_row_pkg::DEF_ROW_LEN
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_valid,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic                       rd_en,
  input  logic [$clog2(ROW_LEN)-1:0] rd_addr,
  input  logic                       rd_release,
  output logic [WORD_W-1:0]          rd_data,
  output logic                       rd_avail,
  output logic                       wr_bank,
  output logic                       swap,
  output logic                       wr_err
);
  localparam int IDX_W = $clog2(ROW_LEN);
  localparam int DEPTH = pp_row_pkg::NUM_BANKS * ROW_LEN;
  localparam int ADR_W = $clog2(DEPTH);

  logic             wr_accept;
  logic [IDX_W-1:0] wr_idx;
  logic [ADR_W-1:0] waddr;
  logic [ADR_W-1:0] raddr;

  pp_row_ctl #(.ROW_LEN(ROW_LEN)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .rd_release (rd_release),
    .wr_accept  (wr_accept),
    .wr_idx     (wr_idx),
    .wr_bank    (wr_bank),
    .swap       (swap),
    .wr_err     (wr_err),
    .rd_avail   (rd_avail)
  );

  // the bank bit is the top address bit; the reader always uses the other bank (R7)
  assign waddr = {wr_bank, wr_idx};
  assign raddr = {~wr_bank, rd_addr};

  pp_row_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_accept),
    .waddr (waddr),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (raddr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/pp_row_buffer_chk.sv
module pp_row_buffer_chk (
  input logic clk,
  input logic rst,
  input logic rd_release,
  input logic rd_avail,
  input logic wr_bank,
  input logic swap,
  input logic wr_err
);
  AST_SWAP_TOGGLES_BANK: assert property (@(posedge clk) disable iff (rst) swap |-> (wr_bank != $past(wr_bank))); // R3
  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (rst) !swap |-> $stable(wr_bank)); // R3
  AST_SWAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) swap |=> !swap); // R3
  AST_SWAP_SETS_AVAIL: assert property (@(posedge clk) disable iff (rst) swap |-> rd_avail); // R4
  AST_AVAIL_DROP_ON_RELEASE: assert property (@(posedge clk) disable iff (rst) $fell(rd_avail) |-> $past(rd_release)); // R4
  AST_ERR_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst) wr_err |-> ($past(rd_avail) && !$past(rd_release))); // R5
  AST_ERR_NO_SWAP: assert property (@(posedge clk) disable iff (rst) wr_err |-> !swap); // R5
endmodule

bind pp_row_buffer pp_row_buffer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_release (rd_release),
  .rd_avail   (rd_avail),
  .wr_bank    (wr_bank),
  .swap       (swap),
  .wr_err     (wr_err)
);

// File: tb/sim_pp_row_buffer.sv
`timescale 1ns/1ps
module sim_pp_row_buffer;
  localparam int W  = 16;
  localparam int L  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_release = 1'b0;
  logic [W-1:0]  rd_data;
  logic          rd_avail, wr_bank, swap, wr_err;

  always #2.5 clk = ~clk;

  pp_row_buffer #(.WORD_W(W), .ROW_LEN(L)) u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_release(rd_release),
    .rd_data(rd_data), .rd_avail(rd_avail), .wr_bank(wr_bank),
    .swap(swap), .wr_err(wr_err)
  );

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic         pend = 1'b0;

  function automatic logic [W-1:0] wa(int i); return W'(16'hA000 + i); endfunction
  function automatic logic [W-1:0] wb(int i); return W'(16'hB100 + 3 * i); endfunction
  function automatic logic [W-1:0] wc(int i); return W'(16'hC0F0 ^ (i << 8)); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: a read issued in one cycle is compared at the following negedge
  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) begin : monitor
    logic [W-1:0] e;
    string t;
    if (pend) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R2: actual unexpected read result %0h expected none", rd_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'(rd_data), 32'(e));
      end
    end
  end

  // driver: one cycle of stimulus, pushes expected read data to the scoreboard
  task automatic drive(bit v, logic [W-1:0] d, bit rel, bit re, logic [AW-1:0] ra,
                       logic [W-1:0] rexp, string rtag);
    wr_valid = v; wr_data = d; rd_release = rel; rd_en = re; rd_addr = ra;
    if (re) begin
      exp_q.push_back(rexp);
      tag_q.push_back(rtag);
    end
    @(negedge clk);
    wr_valid = 1'b0; rd_release = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(logic [W-1:0] d); drive(1'b1, d, 1'b0, 1'b0, '0, '0, ""); endtask
  task automatic idle(); drive(1'b0, '0, 1'b0, 1'b0, '0, '0, ""); endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", 32'(wr_bank), 0);
    check("R1", 32'(rd_avail), 0);
    check("R1", 32'(swap), 0);
    check("R1", 32'(wr_err), 0);
    check("R1", 32'(rd_data), 0);

    idle();
    check("R10", 32'(swap), 0);
    check("R10", 32'(wr_bank), 0);

    // row A into bank 0, with an idle gap in the middle
    for (int i = 0; i < L; i++) begin
      if (i == 4) begin
        idle();
        check("R10", 32'(swap), 0);
      end
      wr(wa(i));
      if (i < L - 1) check("R3", 32'(swap), 0);
    end
    check("R3", 32'(swap), 1);
    check("R3", 32'(wr_bank), 1);
    check("R4", 32'(rd_avail), 1);
    idle();
    check("R3", 32'(swap), 0);
    check("R4", 32'(rd_avail), 1);

    // row B words 0..6 written while row A is read in reverse order
    for (int i = 0; i < L - 1; i++) begin
      drive(1'b1, wb(i), 1'b0, 1'b1, AW'(L - 1 - i), wa(L - 1 - i), "R7");
      check("R9", 32'(wr_err), 0);
      check("R9", 32'(swap), 0);
    end

    // last word without release: refused
    drive(1'b1, 16'hDEAD, 1'b0, 1'b0, '0, '0, "");
    check("R5", 32'(wr_err), 1);
    check("R5", 32'(swap), 0);
    check("R5", 32'(wr_bank), 1);
    idle();
    check("R5", 32'(wr_err), 0);
    check("R4", 32'(rd_avail), 1);
    drive(1'b0, '0, 1'b0, 1'b1, 3'd0, wa(0), "R5");

    drive(1'b0, '0, 1'b1, 1'b0, '0, '0, "");
    check("R4", 32'(rd_avail), 0);

    wr(wb(L - 1));
    check("R5", 32'(swap), 1);
    check("R5", 32'(wr_bank), 0);
    check("R4", 32'(rd_avail), 1);
    for (int i = 0; i < L; i++)
      drive(1'b0, '0, 1'b0, 1'b1, AW'(i), wb(i), "R2");

    drive(1'b0, '0, 1'b0, 1'b1, 3'd3, wb(3), "R8");
    idle();
    idle();
    check("R8", 32'(rd_data), 32'(wb(3)));

    // row C into bank 0: last word arrives with the release
    for (int i = 0; i < L - 1; i++) wr(wc(i));
    drive(1'b1, wc(L - 1), 1'b1, 1'b0, '0, '0, "");
    check("R6", 32'(swap), 1);
    check("R6", 32'(wr_err), 0);
    check("R6", 32'(wr_bank), 1);
    check("R6", 32'(rd_avail), 1);
    for (int i = 0; i < L; i++)
      drive(1'b0, '0, 1'b0, 1'b1, AW'(i), wc(i), "R6");

    drive(1'b0, '0, 1'b1, 1'b0, '0, '0, "");
    check("R4", 32'(rd_avail), 0);
    idle();
    check("R2", 32'(exp_q.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule